// File: doc/BRIEF.md
# Two-Level Multiplexing Storage Path

This block merges several narrow input lanes into one output lane and keeps storage on both sides of the selector. Each input lane has its own hybrid storage cell. The cell is a latch while its own latch enable is high. While that enable is low, it acts as a register that loads on a capture strobe. All input cells share one active-low capture enable. A select field then chooses one lane's stored value as the intermediate value. A second hybrid cell, the output cell, holds that value. It has its own latch enable and its own active-low capture enable.

Everything runs in one system clock domain. The capture strobe is an ordinary input, sampled on every system clock. A rising edge of the strobe, as seen at the system clock, is a capture event. Both storage levels act on the same event, and each one takes the value it saw before the event. This gives a two-stage pipeline: the output cell gets what the selected lane held before that lane was updated. The output-enable pin is active low. While the output is disabled, the block lowers a drive-enable flag and holds the data at zero. The flag takes the place of a high-impedance state.

Top module: `mux_store_path`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears all four lane cells and the output cell to zero. It also sets the strobe history to high, so a strobe that is already high when reset is released does not count as a capture event.
- R2: While `lane_le[i]` is high, lane i's stored value equals `lane_data[i*W +: W]` in the same cycle, whatever the strobe is doing.
- R3: With `lane_le[i]` low, lane i loads its data on a capture event only if `lane_ce_n` is low. In every other case it holds its value.
- R4: `sel` picks the intermediate value: 0 picks lane 0 (bits W-1:0), 1 picks lane 1, 2 picks lane 2 and 3 picks lane 3.
- R5: While `out_le` is high, the output cell passes the intermediate value through in the same cycle.
- R6: With `out_le` low and `out_ce_n` low, the output cell takes the intermediate value on a capture event. It uses the value from before the event, not the lane value loaded by that same event.
- R7: With `out_le` low and `out_ce_n` high, the output cell holds its value through capture events.
- R8: While `out_oe_n` is high, `dout_en` is 0 and `dout` is 0. While `out_oe_n` is low, `dout_en` is 1 and `dout` shows the output cell.
- R9: A capture event occurs in a clock cycle where `strobe` is high and was low in the previous cycle. A strobe held high produces exactly one event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| strobe | input | 1 | Capture strobe; its rising edge is a capture event |
| lane_data | input | LANES*W | Input lanes packed, lane 0 in the low bits |
| lane_le | input | LANES | Per-lane latch enable |
| lane_ce_n | input | 1 | Shared active-low capture enable for the lane cells |
| sel | input | SELW | Lane select |
| out_le | input | 1 | Output cell latch enable |
| out_ce_n | input | 1 | Active-low capture enable for the output cell |
| out_oe_n | input | 1 | Active-low output enable |
| dout | output | W | Output data, zero when disabled |
| dout_en | output | 1 | Drive-enable flag |

## Verification
The bench goes after the moment of a capture event with both levels enabled. A design that let the output cell see the newly loaded lane value would merge the two stages into one, and the output would run one event early. It also holds the strobe high over several cycles and releases reset while the strobe is high. An edge detector that works on level, or that resets its history wrongly, would load more than once. The bench drops a latch enable to low and then toggles the enables. A cell that failed to keep its last transparent value, or that loaded with its capture enable high, would change its stored data when it should hold it.

// File: rtl/msp_pkg.sv
package msp_pkg;
  localparam int unsigned DEF_LANES = 4;
  localparam int unsigned DEF_W     = 8;
  typedef enum logic [1:0] {CELL_TRANSP, CELL_LOAD, CELL_HOLD} cell_mode_e;
endpackage

// File: rtl/strobe_edge.sv
module strobe_edge (
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  output logic event_o
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= strobe;
  end

  assign event_o = strobe & ~prev_q;

  // R9
  single_event_chk: assert property (@(posedge clk) disable iff (rst)
    event_o |=> !event_o);
endmodule

// File: rtl/hyb_cell.sv
module hyb_cell
  import msp_pkg::*;
#(
  parameter int unsigned W = DEF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         le,
  input  logic         ce_n,
  input  logic         cap_evt,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  cell_mode_e   mode;
  logic [W-1:0] store_q;

  always_comb begin
    if (le)                  mode = CELL_TRANSP;
    else if (cap_evt && !ce_n) mode = CELL_LOAD;
    else                     mode = CELL_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) store_q <= '0;
    else if (mode != CELL_HOLD) store_q <= d;
  end

  assign q = (mode == CELL_TRANSP) ? d : store_q;

  // R3 R7
  hold_no_load_chk: assert property (@(posedge clk) disable iff (rst)
    (!le && !(cap_evt && !ce_n)) |=> (le || $stable(q)));
endmodule

// File: rtl/lane_select.sv
module lane_select
  import msp_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned W     = DEF_W,
  localparam int unsigned SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [LANES*W-1:0] lanes,
  input  logic [SELW-1:0]    sel,
  output logic [W-1:0]       mid
);
  always_comb begin
    mid = '0;
    for (int i = 0; i < LANES; i++) begin
      if (sel == SELW'(i)) mid = lanes[i*W +: W];
    end
  end
endmodule

// File: rtl/mux_store_path.sv
module mux_store_path
  import msp_pkg::*;
#(
  parameter int unsigned LANES = DEF_LANES,
  parameter int unsigned W     = DEF_W,
  localparam int unsigned SELW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               strobe,
  input  logic [LANES*W-1:0] lane_data,
  input  logic [LANES-1:0]   lane_le,
  input  logic               lane_ce_n,
  input  logic [SELW-1:0]    sel,
  input  logic               out_le,
  input  logic               out_ce_n,
  input  logic               out_oe_n,
  output logic [W-1:0]       dout,
  output logic               dout_en
);
  logic               cap_evt;
  logic [LANES*W-1:0] lane_q;
  logic [W-1:0]       mid;
  logic [W-1:0]       out_q;

  strobe_edge u_edge (
    .clk(clk), .rst(rst), .strobe(strobe), .event_o(cap_evt)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    hyb_cell #(.W(W)) u_cell (
      .clk(clk), .rst(rst), .le(lane_le[g]), .ce_n(lane_ce_n),
      .cap_evt(cap_evt), .d(lane_data[g*W +: W]), .q(lane_q[g*W +: W])
    );
  end

  lane_select #(.LANES(LANES), .W(W)) u_sel (
    .lanes(lane_q), .sel(sel), .mid(mid)
  );

  hyb_cell #(.W(W)) u_out (
    .clk(clk), .rst(rst), .le(out_le), .ce_n(out_ce_n),
    .cap_evt(cap_evt), .d(mid), .q(out_q)
  );

  assign dout_en = ~out_oe_n;
  assign dout    = out_oe_n ? '0 : out_q;

  // R5
  out_transp_chk: assert property (@(posedge clk) disable iff (rst)
    (out_le && !out_oe_n) |-> (dout == mid));
  // R6
  out_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (cap_evt && !out_le && !out_ce_n) |=> (out_le || out_q == $past(mid)));
  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_le && out_ce_n) |=> (out_le || $stable(out_q)));
  // R8
  out_disabled_chk: assert property (@(posedge clk) disable iff (rst)
    out_oe_n |-> (!dout_en && dout == '0));
endmodule

// File: tb/mux_store_path_tb_top.sv
module mux_store_path_tb_top;
  localparam int LANES = 4;
  localparam int W = 8;

  logic clk = 0;
  logic rst = 1;
  logic strobe = 0;
  logic [LANES*W-1:0] lane_data = '0;
  logic [LANES-1:0] lane_le = '0;
  logic lane_ce_n = 1;
  logic [1:0] sel = 0;
  logic out_le = 0, out_ce_n = 1, out_oe_n = 0;
  logic [W-1:0] dout;
  logic dout_en;

  int errors = 0, checks = 0;
  logic [W-1:0] m_lane [LANES];
  logic [W-1:0] m_out;
  logic m_prev;

  always #4 clk = ~clk;

  mux_store_path #(.LANES(LANES), .W(W)) dut_i (
    .clk(clk), .rst(rst), .strobe(strobe), .lane_data(lane_data),
    .lane_le(lane_le), .lane_ce_n(lane_ce_n), .sel(sel), .out_le(out_le),
    .out_ce_n(out_ce_n), .out_oe_n(out_oe_n), .dout(dout), .dout_en(dout_en)
  );

  function automatic logic [W-1:0] lane_view(int i);
    return lane_le[i] ? lane_data[i*W +: W] : m_lane[i];
  endfunction

  task automatic check(string tag, logic [W:0] act, logic [W:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: dout_en/dout actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // One cycle: compare model vs outputs mid-cycle, then advance the model.
  task automatic step(string tag);
    logic [W-1:0] mid, oq, nl [LANES], no;
    logic ev;
    #1;
    mid = lane_view(int'(sel));
    oq = out_le ? mid : m_out;
    check(tag, {dut_i.dout_en, dout}, out_oe_n ? {1'b0, {W{1'b0}}} : {1'b1, oq});
    ev = strobe && !m_prev;
    for (int i = 0; i < LANES; i++) begin
      nl[i] = m_lane[i];
      if (lane_le[i] || (ev && !lane_ce_n)) nl[i] = lane_data[i*W +: W];
    end
    no = m_out;
    if (out_le || (ev && !out_ce_n)) no = mid;
    @(posedge clk);
    if (rst) begin
      for (int i = 0; i < LANES; i++) m_lane[i] = '0;
      m_out = '0; m_prev = 1'b1;
    end else begin
      for (int i = 0; i < LANES; i++) m_lane[i] = nl[i];
      m_out = no; m_prev = strobe;
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < LANES; i++) m_lane[i] = 'x;
    m_out = 'x; m_prev = 1'bx;
    @(negedge clk);
    // R1: reset, strobe high across release
    rst = 1; strobe = 1; lane_data = 32'hA1B2C3D4; lane_ce_n = 0; out_ce_n = 0;
    @(posedge clk);
    for (int i = 0; i < LANES; i++) m_lane[i] = '0;
    m_out = '0; m_prev = 1'b1;
    @(negedge clk);
    rst = 0;
    step("R1 reset out");
    step("R9 held strobe after reset");
    out_le = 1;
    for (int i = 0; i < LANES; i++) begin sel = 2'(i); step("R1 lane cleared"); end
    // R2 transparency on lane 2
    lane_le = 4'b0100; sel = 2; lane_data[23:16] = 8'h5A; step("R2 transparent");
    lane_data[23:16] = 8'h3C; strobe = 0; step("R2 follows data");
    lane_le = 0; lane_data[23:16] = 8'h99; step("R2 keeps last value");
    // R3 load on edge with ce low
    lane_ce_n = 0; lane_data = 32'h44332211; strobe = 1; out_le = 0; out_ce_n = 1;
    step("R3 edge load");
    out_le = 1; lane_data = 32'hEEEEEEEE;
    for (int i = 0; i < LANES; i++) begin sel = 2'(i); step("R4 select lane / R9 no re-load"); end
    lane_ce_n = 1; strobe = 0; step("R3 setup");
    strobe = 1; step("R3 ce high no load");
    sel = 0; step("R3 hold check");
    // R6 pipeline: output captures pre-edge lane value
    out_le = 0; out_ce_n = 0; lane_ce_n = 0; strobe = 0; lane_data = 32'h0000007F;
    step("R6 setup");
    strobe = 1; step("R6 capture edge");
    step("R6 old value kept");
    strobe = 0; step("R6 low");
    strobe = 1; step("R6 second edge");
    step("R6 new value");
    // R7 hold with out_ce_n high
    out_ce_n = 1; lane_data = 32'h00000010; strobe = 0; step("R7 setup");
    strobe = 1; step("R7 edge");
    step("R7 held");
    // R8 disable
    out_oe_n = 1; out_le = 1; step("R8 disabled");
    out_oe_n = 0; step("R8 enabled");
    // R5 output transparency
    out_le = 1; lane_le = 4'b1111; sel = 3; lane_data = 32'h5500_0000; step("R5 transparent");
    // Random phase
    for (int n = 0; n < 3000; n++) begin
      lane_data = $urandom;
      lane_le = 4'($urandom) & 4'($urandom);
      lane_ce_n = 1'($urandom); sel = 2'($urandom);
      out_le = (($urandom % 4) == 0); out_ce_n = 1'($urandom);
      out_oe_n = (($urandom % 6) == 0); strobe = 1'($urandom);
      rst = (($urandom % 500) == 0);
      step("R4 R6 R7 random");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule